// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory. Its address, control and data paths are all registered. A command is sampled on one enabled clock edge. Two enabled edges later the word moves. For a write, the data is taken from `din` on that edge. For a read, the data appears on `dout` just after that edge. Reads and writes share the same two-edge delay, so they can alternate on every cycle with no idle slot between them.

Each command is one of three kinds:
- a load, which gives a new address and a new direction;
- an advance, which steps an internal four-beat burst counter and keeps the direction chosen at the load;
- a deselect or no-op, which moves no data.

The burst order is linear or interleaved, selected by a static input. A clock-enable suspend makes an edge have no effect at all, so the whole pipeline and the outputs freeze.

A tri-state data bus is modelled by three signals: `din`, `dout`, and a registered drive flag, `bus_drive`. An asynchronous output enable gates the drive flag.

Top module: `zbt_sram`

## Requirements
- R1: A synchronous reset (`rst` high) clears every pending command. After the first rising edge with `rst` high, `bus_drive` is low, and it stays low until a read issued after reset reaches its data slot.
- R2: A write load samples address, data direction and lane enables on edge E0, and takes `din` on the second enabled edge after E0. The byte lanes are defined as follows:
  - lane k covers bits [9k+8:9k];
  - lane k is written only when `lane_we_n[k]` was 0 in the command's cycle.
- R3: A read load on edge E0 puts the addressed word on `dout`, with `bus_drive` high, right after the second enabled edge following E0.
- R4: An edge where `clk_en_n` is high has no effect, whatever the other inputs are:
  - `dout` and `bus_drive` keep their values;
  - no stored word changes;
  - commands already in the pipeline complete, delayed by the number of held edges.
- R5: A deselect has no data slot. It occurs when `load_n` is 0 and any one enable is false (`sel_a_n`=1, `sel_b_n`=1 or `sel_c`=0). `bus_drive` stays low in that command's slot. Reads and writes issued before the deselect still complete.
- R6: A cycle with `load_n`=1 and no burst in progress is a no-op. This is the case after reset or after a deselect. `bus_drive` is low in that command's data slot.
- R7: With `interleave`=0, each advance moves to the next address of the burst. The next address is the load address with bits [1:0] replaced by (start+n) mod 4. Here n is the number of advances, and the count wraps after four beats.
- R8: With `interleave`=1, the address for advance n has bits [1:0] equal to start XOR (n mod 4).
- R9: During an advance, `addr` and `wr_n` are ignored, and the burst keeps the direction from its load. The lane enables are sampled anew on each burst-write beat.
- R10: The lane enables have no effect on a read, so the stored word is left unchanged.
- R11: Reads and writes may follow each other on consecutive cycles. `bus_drive` is low in every write slot and high in every read slot.
- R12: `out_en_n` high forces `bus_drive` low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Edge enable, active low; high suspends the edge |
| sel_a_n | input | 1 | Select term, active low |
| sel_b_n | input | 1 | Select term, active low |
| sel_c | input | 1 | Select term, active high |
| load_n | input | 1 | 0 = load new command, 1 = advance burst |
| wr_n | input | 1 | 0 = write, 1 = read (loads only) |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| interleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data, taken in the write slot |
| dout | output | LANES*LANE_W | Registered read data |
| bus_drive | output | 1 | Output-drive flag for `dout` |

## Verification
The hardest state to reach is a pending write whose data slot falls behind held edges or behind a deselect. The slot then has to take `din` on the correct enabled edge even though garbage write commands are presented during the holds. The bench reaches this state with write loads followed by held edges that carry full-select write loads with random address and data, and by deselects issued right after writes. It then reads the addresses back. Burst wrap and the advance-ignores-inputs rule are driven by five-beat bursts whose advance cycles present `wr_n`=0 and a foreign address.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input logic              ilv
  );
    return ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load_n,
  input  logic              sel,
  input  logic              wr_n,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] ext_addr,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic              active_q;
  logic              dir_wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nx;

  assign beat_nx = beat_q + 1'b1;

  always_comb begin
    cmd_op   = OP_NONE;
    cmd_addr = base_q;
    if (!load_n) begin
      cmd_addr = ext_addr;
      if (sel) cmd_op = wr_n ? OP_READ : OP_WRITE;
    end else if (active_q) begin
      cmd_op   = dir_wr_q ? OP_WRITE : OP_READ;
      cmd_addr = {base_q[ADDR_W-1:BEAT_W],
                  beat_offset(base_q[BEAT_W-1:0], beat_nx, interleave)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      dir_wr_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (en) begin
      if (!load_n) begin
        active_q <= sel;
        dir_wr_q <= !wr_n;
        base_q   <= ext_addr;
        beat_q   <= '0;
      end else if (active_q) begin
        beat_q <= beat_nx;
      end
    end
  end
endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  op_e               op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  lane_n_in,
  output op_e               slot_op,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [LANES-1:0]  slot_lane_we
);
  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lwe;
  } stage_t;

  stage_t st_in;
  stage_t stg [STAGES];

  always_comb begin
    st_in.op   = op_in;
    st_in.addr = addr_in;
    st_in.lwe  = (op_in == OP_WRITE) ? ~lane_n_in : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else if (en) begin
      stg[0] <= st_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign slot_op      = stg[STAGES-1].op;
  assign slot_addr    = stg[STAGES-1].addr;
  assign slot_lane_we = stg[STAGES-1].lwe;
endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  op_e                     op,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] ram [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en && op == OP_WRITE && lane_we[k])
        ram[addr] <= wdata[k*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) rd_q <= '0;
      else if (en && op == OP_READ) rd_q <= ram[addr];
    end

    assign rdata[k*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic                    load_n,
  input  logic                    wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    interleave,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    bus_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  logic              sel;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  op_e               slot_op;
  logic [ADDR_W-1:0] slot_addr;
  logic [LANES-1:0]  slot_lane_we;
  logic [DATA_W-1:0] rdata;
  logic              drive_q;

  assign en  = !clk_en_n;
  assign sel = !sel_a_n && !sel_b_n && sel_c;

  zbt_burst_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst(rst), .en(en), .load_n(load_n), .sel(sel),
    .wr_n(wr_n), .interleave(interleave), .ext_addr(addr),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  zbt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(2)) pipe_i (
    .clk(clk), .rst(rst), .en(en), .op_in(cmd_op), .addr_in(cmd_addr),
    .lane_n_in(lane_we_n), .slot_op(slot_op), .slot_addr(slot_addr),
    .slot_lane_we(slot_lane_we)
  );

  zbt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
    .clk(clk), .rst(rst), .en(en), .op(slot_op), .addr(slot_addr),
    .lane_we(slot_lane_we), .wdata(din), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else if (en) drive_q <= (slot_op == OP_READ);
  end

  assign dout      = rdata;
  assign bus_drive = drive_q && !out_en_n;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              sel_a_n,
  input logic              sel_b_n,
  input logic              sel_c,
  input logic              load_n,
  input logic              wr_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] dout,
  input logic              bus_drive
);
  // shadow per stage: [2] may drive, [1] loaded write, [0] loaded read
  logic [2:0] sh0, sh1, sh2;
  logic       sel;
  logic [2:0] cmd_bits;

  assign sel = !sel_a_n && !sel_b_n && sel_c;
  assign cmd_bits = {(load_n || (sel && wr_n)),
                     (!load_n && sel && !wr_n),
                     (!load_n && sel && wr_n)};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh0 <= '0; sh1 <= '0; sh2 <= '0;
    end else if (!clk_en_n) begin
      sh0 <= cmd_bits; sh1 <= sh0; sh2 <= sh1;
    end
  end

  a_r1_no_drive_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !bus_drive);
  a_r3_read_slot_drives: assert property (@(posedge clk) disable iff (rst)
    (sh2[0] && !out_en_n) |-> bus_drive);
  a_r11_write_slot_released: assert property (@(posedge clk) disable iff (rst)
    sh2[1] |-> !bus_drive);
  a_r5_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> sh2[2]);
  a_r12_oe_blocks_drive: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !bus_drive);
  a_r4_hold_keeps_data: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> $stable(dout));
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(LANES*LANE_W)) chk_i (
  .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
  .sel_b_n(sel_b_n), .sel_c(sel_c), .load_n(load_n), .wr_n(wr_n),
  .out_en_n(out_en_n), .dout(dout), .bus_drive(bus_drive)
);

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
  logic        clk, rst, clk_en_n, sel_a_n, sel_b_n, sel_c, load_n, wr_n;
  logic [7:0]  addr;
  logic [3:0]  lane_we_n;
  logic        interleave, out_en_n;
  logic [35:0] din, dout;
  logic        bus_drive;

  zbt_sram dut_i (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .sel_c(sel_c), .load_n(load_n), .wr_n(wr_n),
    .addr(addr), .lane_we_n(lane_we_n), .interleave(interleave),
    .out_en_n(out_en_n), .din(din), .dout(dout), .bus_drive(bus_drive)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit vld; bit wr; logic [7:0] a; logic [3:0] ln; logic [35:0] d; string req;
  } pend_t;
  typedef struct { bit drive; logic [35:0] data; string req; } exp_t;

  exp_t        q[$];
  pend_t       p0, p1;
  logic [35:0] model [256];
  bit          b_act, b_wr;
  logic [7:0]  b_base;
  logic [1:0]  b_cnt;
  bit          oe_sel;
  int          total, bad;
  bit          done;
  logic [35:0] last_dout;
  logic        last_drive;
  bit          en_s, rs_s;
  exp_t        me;

  function automatic pend_t idle_item();
    pend_t it;
    it.vld = 0; it.wr = 0; it.a = '0; it.ln = '1; it.d = '0; it.req = "R6";
    return it;
  endfunction

  function automatic logic [35:0] pat(input logic [7:0] a, input logic [3:0] s);
    return {a, ~a, a ^ {s, s}, a + 8'd3, s};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit ld_n, input bit sa_n, input bit sb_n, input bit sc,
                      input bit wn, input logic [7:0] a, input logic [3:0] ln,
                      input logic [35:0] d, input string req);
    pend_t it, sl;
    exp_t  e;
    bit    sel;
    @(negedge clk);
    clk_en_n = 0; load_n = ld_n; sel_a_n = sa_n; sel_b_n = sb_n; sel_c = sc;
    wr_n = wn; addr = a; lane_we_n = ln; out_en_n = oe_sel;
    sl  = p1;
    din = (sl.vld && sl.wr) ? sl.d : 36'h5_A5A5_A5A5;
    sel = !sa_n && !sb_n && sc;
    it = idle_item(); it.req = req;
    if (!ld_n) begin
      if (sel) begin
        b_act = 1; b_base = a; b_cnt = 0; b_wr = !wn;
        it.vld = 1; it.wr = !wn; it.a = a;
      end else b_act = 0;
    end else if (b_act) begin
      b_cnt++;
      it.vld = 1; it.wr = b_wr;
      it.a = {b_base[7:2], interleave ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
    end
    it.ln = ln; it.d = d;
    if (sl.vld && sl.wr)
      for (int k = 0; k < 4; k++)
        if (!sl.ln[k]) model[sl.a][9*k +: 9] = sl.d[9*k +: 9];
    e.drive = sl.vld && !sl.wr && !oe_sel;
    e.data  = model[sl.a];
    e.req   = sl.req;
    q.push_back(e);
    p1 = p0; p0 = it;
    @(posedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [35:0] d, input logic [3:0] ln,
                    input string req);
    step(0, 0, 0, 1, 0, a, ln, d, req);
  endtask
  task automatic rd(input logic [7:0] a, input string req);
    step(0, 0, 0, 1, 1, a, 4'hF, 36'h0, req);
  endtask
  task automatic adv(input bit wn, input logic [3:0] ln, input logic [35:0] d,
                     input string req);
    step(1, 0, 0, 1, wn, 8'hFF, ln, d, req);
  endtask
  task automatic nop(input string req);
    step(1, 0, 0, 1, 1, 8'h00, 4'hF, 36'h0, req);
  endtask
  task automatic desel(input int k, input bit wn, input string req);
    step(0, k == 0, k == 1, k != 2, wn, 8'hEE, 4'h0, 36'h0, req);
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clk_en_n = 1; load_n = 0; sel_a_n = 0; sel_b_n = 0; sel_c = 1; wr_n = 0;
      addr = 8'($urandom); lane_we_n = 4'h0; din = {4'h9, 32'($urandom)};
      @(posedge clk);
    end
  endtask

  task automatic oe_pulse();
    @(negedge clk);
    clk_en_n = 1;
    out_en_n = 1;
    #0.5;
    check(bus_drive === 1'b0, "R12", "drive while oe high", 36'(bus_drive), 36'h0);
    out_en_n = 0;
    #0.5;
    check(bus_drive === 1'b1, "R12", "drive after oe low", 36'(bus_drive), 36'h1);
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; clk_en_n = 0; load_n = 1; out_en_n = oe_sel;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    q.delete();
    p0 = idle_item(); p1 = idle_item(); b_act = 0;
    check(bus_drive === 1'b0, "R1", "drive after reset", 36'(bus_drive), 36'h0);
  endtask

  // monitor: pops one expected result per enabled edge, checks freeze on held edges
  always begin
    @(posedge clk);
    en_s = !clk_en_n; rs_s = rst;
    #1;
    if (rs_s) begin
      last_dout = dout; last_drive = bus_drive;
    end else if (en_s) begin
      if (q.size() != 0) begin
        me = q.pop_front();
        check(bus_drive === me.drive, me.req, "bus_drive", 36'(bus_drive), 36'(me.drive));
        if (me.drive) check(dout === me.data, me.req, "dout", dout, me.data);
      end
      last_dout = dout; last_drive = bus_drive;
    end else begin
      check(dout === last_dout, "R4", "dout held", dout, last_dout);
      check(bus_drive === last_drive, "R4", "drive held", 36'(bus_drive), 36'(last_drive));
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; clk_en_n = 0; load_n = 1; sel_a_n = 0; sel_b_n = 0; sel_c = 1;
    wr_n = 1; addr = 0; lane_we_n = 4'hF; interleave = 0; out_en_n = 0;
    din = 0; oe_sel = 0; total = 0; bad = 0; done = 0;
    p0 = idle_item(); p1 = idle_item();
    repeat (2) @(posedge clk);
    do_reset();

    // R6: advance with no burst after reset
    nop("R6"); nop("R6");

    // R2 / R3: plain writes then reads
    for (int i = 0; i < 4; i++) wr(8'h10 + 8'(i), pat(8'h10 + 8'(i), 4'h1), 4'h0, "R2");
    for (int i = 0; i < 4; i++) rd(8'h10 + 8'(i), "R3");

    // R11: back-to-back alternation
    wr(8'h30, pat(8'h30, 4'h2), 4'h0, "R11");
    rd(8'h10, "R11");
    wr(8'h31, pat(8'h31, 4'h3), 4'h0, "R11");
    rd(8'h30, "R11");
    rd(8'h31, "R11");
    wr(8'h30, pat(8'h30, 4'h7), 4'h0, "R11");
    rd(8'h30, "R11");

    // R2 lanes, R10 lanes ignored on read
    wr(8'h20, 36'h1_2345_6789, 4'h0, "R2");
    wr(8'h20, 36'hF_FFFF_FFFF, 4'b1010, "R2");
    rd(8'h20, "R2");
    step(0, 0, 0, 1, 1, 8'h20, 4'h0, 36'h0, "R10");
    rd(8'h20, "R10");

    // R4: held edges inside the pipeline
    rd(8'h10, "R4"); hold(3); rd(8'h11, "R4"); hold(1);
    wr(8'h70, pat(8'h70, 4'h4), 4'h0, "R4"); hold(2);
    nop("R4"); hold(2); nop("R4");
    rd(8'h70, "R4"); nop("R4"); nop("R4");

    // R12: asynchronous output enable
    rd(8'h12, "R12"); nop("R12"); nop("R12");
    oe_pulse();
    oe_sel = 1; rd(8'h13, "R12"); nop("R12"); nop("R12");
    oe_sel = 0; nop("R12");

    // R5: deselect variants, pending transfers complete
    rd(8'h10, "R5"); desel(0, 1, "R5"); rd(8'h11, "R5"); desel(1, 1, "R5");
    desel(2, 0, "R5");
    wr(8'h72, pat(8'h72, 4'h5), 4'h0, "R5"); desel(0, 0, "R5"); desel(2, 1, "R5");
    rd(8'h72, "R5");
    nop("R6"); nop("R6");

    // burst setup
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(i), pat(8'h40 + 8'(i), 4'h6), 4'h0, "R2");
    for (int i = 0; i < 4; i++) wr(8'h50 + 8'(i), pat(8'h50 + 8'(i), 4'h8), 4'h0, "R2");

    // R7 linear with wrap; advances present write and foreign address (R9)
    interleave = 0;
    rd(8'h42, "R7");
    for (int i = 0; i < 4; i++) adv(0, 4'h0, 36'h0, "R7");
    desel(0, 1, "R5");
    // R8 interleaved
    interleave = 1;
    rd(8'h41, "R8");
    for (int i = 0; i < 4; i++) adv(0, 4'h0, 36'h0, "R8");
    desel(1, 1, "R5");
    interleave = 0;

    // R9 burst write: direction kept, lanes per beat
    wr(8'h51, pat(8'h61, 4'h9), 4'h0, "R9");
    adv(1, 4'h0, pat(8'h62, 4'hA), "R9");
    adv(1, 4'b0011, pat(8'h63, 4'hB), "R9");
    adv(1, 4'b1110, pat(8'h64, 4'hC), "R9");
    desel(2, 1, "R9"); nop("R9");
    for (int i = 0; i < 4; i++) rd(8'h50 + 8'(i), "R9");
    nop("R9"); nop("R9");

    // R1: reset drops a pending read
    wr(8'h60, pat(8'h60, 4'hD), 4'h0, "R1"); nop("R1"); nop("R1");
    rd(8'h60, "R1");
    do_reset();
    nop("R1"); nop("R1"); nop("R1");

    hold(2);
    check(q.size() == 0, "R3", "results pending", 36'(q.size()), 36'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule